// File: doc/BRIEF.md
# Product-Term Sum and XOR Cell Slice

This block is the combinational logic slice of one cell in a programmable logic array. It builds five product terms from a shared input vector. Each term is the AND of the literals picked by a per-term mask. A routing word sends each term either into the cell's local OR sum or out on a dedicated control line, where a register stage or enable logic elsewhere can use it.

The local sum can be widened in two ways. A cascade input from the neighbouring cell can be ORed in, and the cell repeats the widened sum on a cascade output so that cells can be chained. A set of regional foldback lines can also be ORed in, each under its own enable. The sum then passes through an XOR stage. The XOR's second operand is a constant zero, a constant one, a chosen product term or that term's complement. This gives polarity control and arithmetic-style functions.

Each cell also drives one foldback line: the complement of a chosen product term, for its neighbours in the region. There is no clocked storage, pin logic or routing fabric here.

Top module: `ptcell_slice`

## Requirements
- R1: Mask bit 2*i of a term enables the true literal of input i, and bit 2*i+1 enables its complement. The term is the AND of all enabled literals, so enabling both literals of one input forces the term to 0.
- R2: A term whose mask is all zeros evaluates to 1.
- R3: When route bit t is 1, term t enters the OR sum and ctrl_o[t] is 0. When route bit t is 0, term t appears on ctrl_o[t] and does not enter the sum.
- R4: When casc_en_i is 1, casc_i is ORed into the sum. When casc_en_i is 0, casc_i has no effect on sum_o, casc_o or xor_o.
- R5: Each bit k of fb_use_i that is set ORs fb_bus_i[k] into the sum. A cleared bit excludes that line.
- R6: casc_o always equals sum_o, and sum_o includes the cascade and foldback contributions.
- R7: When xor_sel_i is 2'b00, xor_o equals sum_o. When xor_sel_i is 2'b01, xor_o is the complement of sum_o.
- R8: When xor_sel_i is 2'b10, xor_o is sum_o XOR term[xor_idx_i]. When xor_sel_i is 2'b11, xor_o is sum_o XOR NOT term[xor_idx_i].
- R9: fb_o is the complement of term[fb_sel_i].
- R10: An index of 5 or more in xor_idx_i or fb_sel_i reads as a term of value 1. For such an index, fb_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | N_IN | Input signals seen by every term |
| mask_i | input | N_PT x 2*N_IN | Per-term literal enables (true, complement) |
| route_i | input | N_PT | 1 = term to OR sum, 0 = term to control line |
| casc_en_i | input | 1 | Enables the cascade input into the sum |
| casc_i | input | 1 | Cascade sum from the neighbouring cell |
| fb_bus_i | input | N_FB | Regional foldback lines |
| fb_use_i | input | N_FB | Per-line foldback enables into the sum |
| xor_sel_i | input | 2 | XOR second operand: 0, 1, term, inverted term |
| xor_idx_i | input | IDX_W | Term index for the XOR operand |
| fb_sel_i | input | IDX_W | Term index driven inverted on fb_o |
| ctrl_o | output | N_PT | Terms not routed to the sum |
| sum_o | output | 1 | OR sum including cascade and foldback |
| casc_o | output | 1 | Cascade output to the next cell |
| xor_o | output | 1 | XOR stage result |
| fb_o | output | 1 | Inverted selected term for the region |

## Verification
The embedded checks are immediate and combinational. They assume every input is a settled 0 or 1 when they evaluate, with no X or Z values. The bench meets this by driving every port from a fully specified vector on the rising clock edge and sampling at the falling edge. Random vectors draw their indices over the full field width, so the out-of-range indices of R10 are covered along with the five valid ones.

// File: rtl/ptcell_pkg.sv
package ptcell_pkg;

  // Source of the second XOR operand.
  typedef enum logic [1:0] {
    XS_ZERO   = 2'b00,
    XS_ONE    = 2'b01,
    XS_TERM   = 2'b10,
    XS_TERM_N = 2'b11
  } xor_src_e;

endpackage

// File: rtl/pt_and_array.sv
module pt_and_array #(
  parameter int N_IN = 8,
  parameter int N_PT = 5
) (
  input  logic [N_IN-1:0]                 in_i,
  input  logic [N_PT-1:0][2*N_IN-1:0]     mask_i,
  output logic [N_PT-1:0]                 pt_o
);

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic acc;

    always_comb begin
      acc = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (mask_i[t][2*i]   && !in_i[i]) acc = 1'b0;
        if (mask_i[t][2*i+1] &&  in_i[i]) acc = 1'b0;
      end
    end

    assign pt_o[t] = acc;

    always_comb begin
      // R2
      if (mask_i[t] == '0) empty_term_chk: assert (pt_o[t]);
      // R1
      if (mask_i[t][0] && mask_i[t][1]) contra_lit_chk: assert (!pt_o[t]);
    end
  end

endmodule

// File: rtl/pt_pick.sv
module pt_pick #(
  parameter int N_PT  = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_PT-1:0]  pt_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);

  // Out-of-range index reads as an empty term (1).
  always_comb begin
    bit_o = 1'b1;
    for (int t = 0; t < N_PT; t++) begin
      if (idx_i == IDX_W'(t)) bit_o = pt_i[t];
    end
  end

endmodule

// File: rtl/pt_steer.sv
module pt_steer #(
  parameter int N_PT = 5,
  parameter int N_FB = 4
) (
  input  logic [N_PT-1:0] pt_i,
  input  logic [N_PT-1:0] route_i,
  input  logic            casc_en_i,
  input  logic            casc_i,
  input  logic [N_FB-1:0] fb_bus_i,
  input  logic [N_FB-1:0] fb_use_i,
  output logic [N_PT-1:0] ctrl_o,
  output logic            sum_o
);

  logic local_or;
  logic fb_or;
  logic casc_term;

  always_comb begin
    local_or = 1'b0;
    for (int t = 0; t < N_PT; t++) begin
      ctrl_o[t] = pt_i[t] & ~route_i[t];
      if (route_i[t]) local_or = local_or | pt_i[t];
    end
  end

  always_comb begin
    fb_or = 1'b0;
    for (int k = 0; k < N_FB; k++) begin
      if (fb_use_i[k]) fb_or = fb_or | fb_bus_i[k];
    end
  end

  assign casc_term = casc_en_i & casc_i;
  assign sum_o     = local_or | fb_or | casc_term;

  always_comb begin
    // R3
    if (|(pt_i & route_i)) routed_sum_chk: assert (sum_o);
    // R4
    if (!casc_en_i && !(|(pt_i & route_i)) && !(|(fb_bus_i & fb_use_i)))
      casc_off_chk: assert (!sum_o);
  end

endmodule

// File: rtl/xor_stage.sv
module xor_stage
  import ptcell_pkg::*;
(
  input  logic       sum_i,
  input  logic       term_i,
  input  logic [1:0] sel_i,
  output logic       xor_o
);

  xor_src_e src;
  logic     operand;

  assign src = xor_src_e'(sel_i);

  always_comb begin
    unique case (src)
      XS_ZERO:   operand = 1'b0;
      XS_ONE:    operand = 1'b1;
      XS_TERM:   operand = term_i;
      XS_TERM_N: operand = ~term_i;
      default:   operand = 1'b0;
    endcase
  end

  assign xor_o = sum_i ^ operand;

  always_comb begin
    // R7
    if (src == XS_ZERO) pass_chk: assert (xor_o == sum_i);
    // R7
    if (src == XS_ONE) invert_chk: assert (xor_o != sum_i);
  end

endmodule

// File: rtl/ptcell_slice.sv
module ptcell_slice #(
  parameter int N_IN = 8,
  parameter int N_PT = 5,
  parameter int N_FB = 4,
  localparam int IDX_W = $clog2(N_PT)
) (
  input  logic [N_IN-1:0]             in_i,
  input  logic [N_PT-1:0][2*N_IN-1:0] mask_i,
  input  logic [N_PT-1:0]             route_i,
  input  logic                        casc_en_i,
  input  logic                        casc_i,
  input  logic [N_FB-1:0]             fb_bus_i,
  input  logic [N_FB-1:0]             fb_use_i,
  input  logic [1:0]                  xor_sel_i,
  input  logic [IDX_W-1:0]            xor_idx_i,
  input  logic [IDX_W-1:0]            fb_sel_i,
  output logic [N_PT-1:0]             ctrl_o,
  output logic                        sum_o,
  output logic                        casc_o,
  output logic                        xor_o,
  output logic                        fb_o
);

  logic [N_PT-1:0] pt;
  logic            sum;
  logic            xor_term;
  logic            fb_term;

  pt_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .in_i   (in_i),
    .mask_i (mask_i),
    .pt_o   (pt)
  );

  pt_steer #(.N_PT(N_PT), .N_FB(N_FB)) u_steer (
    .pt_i      (pt),
    .route_i   (route_i),
    .casc_en_i (casc_en_i),
    .casc_i    (casc_i),
    .fb_bus_i  (fb_bus_i),
    .fb_use_i  (fb_use_i),
    .ctrl_o    (ctrl_o),
    .sum_o     (sum)
  );

  pt_pick #(.N_PT(N_PT), .IDX_W(IDX_W)) u_xor_pick (
    .pt_i  (pt),
    .idx_i (xor_idx_i),
    .bit_o (xor_term)
  );

  pt_pick #(.N_PT(N_PT), .IDX_W(IDX_W)) u_fb_pick (
    .pt_i  (pt),
    .idx_i (fb_sel_i),
    .bit_o (fb_term)
  );

  xor_stage u_xor (
    .sum_i  (sum),
    .term_i (xor_term),
    .sel_i  (xor_sel_i),
    .xor_o  (xor_o)
  );

  assign sum_o  = sum;
  assign casc_o = sum;
  assign fb_o   = ~fb_term;

  always_comb begin
    // R10
    if (int'(fb_sel_i) >= N_PT) fb_range_chk: assert (!fb_o);
    // R9
    if (int'(fb_sel_i) < N_PT && fb_o) fb_zero_term_chk: assert (!(&pt));
  end

endmodule

// File: tb/tb_ptcell_slice.sv
module tb_ptcell_slice;

  localparam int N_IN  = 8;
  localparam int N_PT  = 5;
  localparam int N_FB  = 4;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N_IN-1:0]             in_i;
  logic [N_PT-1:0][2*N_IN-1:0] mask_i;
  logic [N_PT-1:0]             route_i;
  logic                        casc_en_i, casc_i;
  logic [N_FB-1:0]             fb_bus_i, fb_use_i;
  logic [1:0]                  xor_sel_i;
  logic [IDX_W-1:0]            xor_idx_i, fb_sel_i;
  logic [N_PT-1:0]             ctrl_o;
  logic                        sum_o, casc_o, xor_o, fb_o;

  ptcell_slice dut (.*);

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct packed {
    logic [7:0]  vin;
    logic [15:0] m4, m3, m2, m1, m0;
    logic [4:0]  route;
    logic        cen, cin;
    logic [3:0]  fbin, fbuse;
    logic [1:0]  xsel;
    logic [2:0]  xidx, fbsel;
    logic [4:0]  e_ctrl;
    logic        e_sum, e_xor, e_fb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    // V0 empty terms all routed (R2, R3)
    '{8'hA5, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 5'h1F, 1'b0, 1'b0, 4'h0, 4'h0, 2'b00, 3'd0, 3'd0, 5'h00, 1'b1, 1'b1, 1'b0},
    // V1 term0 true, others false (R1, R7, R9)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h1F, 1'b0, 1'b0, 4'h0, 4'h0, 2'b01, 3'd0, 3'd1, 5'h00, 1'b1, 1'b0, 1'b1},
    // V2 term0 to control (R3, R8)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h1E, 1'b0, 1'b0, 4'h0, 4'h0, 2'b10, 3'd0, 3'd0, 5'h01, 1'b0, 1'b1, 1'b0},
    // V3 cascade on (R4, R6)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h1E, 1'b1, 1'b1, 4'h0, 4'h0, 2'b00, 3'd0, 3'd0, 5'h01, 1'b1, 1'b1, 1'b0},
    // V4 cascade input ignored when disabled (R4)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h1E, 1'b0, 1'b1, 4'h0, 4'h0, 2'b00, 3'd0, 3'd0, 5'h01, 1'b0, 1'b0, 1'b0},
    // V5 enabled foldback line high (R5)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h00, 1'b0, 1'b0, 4'h4, 4'h4, 2'b01, 3'd0, 3'd0, 5'h01, 1'b1, 1'b0, 1'b0},
    // V6 only disabled foldback lines high (R5)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h00, 1'b0, 1'b0, 4'hB, 4'h4, 2'b01, 3'd0, 3'd0, 5'h01, 1'b0, 1'b1, 1'b0},
    // V7 mixed literals, contradictory term0 (R1, R8, R9)
    '{8'hA5, 16'h4010, 16'h0008, 16'h0004, 16'h0000, 16'h0003, 5'h01, 1'b0, 1'b0, 4'h0, 4'h0, 2'b10, 3'd3, 3'd4, 5'h1A, 1'b0, 1'b1, 1'b0},
    // V8 inverted term operand, foldback index out of range (R8, R10)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h1E, 1'b0, 1'b0, 4'h0, 4'h0, 2'b11, 3'd1, 3'd7, 5'h01, 1'b0, 1'b1, 1'b0},
    // V9 XOR index out of range reads 1 (R10, R9)
    '{8'hA5, 16'h2, 16'h2, 16'h2, 16'h2, 16'h1, 5'h1E, 1'b0, 1'b0, 4'h0, 4'h0, 2'b10, 3'd6, 3'd2, 5'h01, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench model written from the requirements.
  function automatic logic term_of(logic [7:0] v, logic [15:0] m);
    logic r = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (m[2*i] && v[i] == 1'b0) r = 1'b0;
      if (m[2*i+1] && v[i] == 1'b1) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic pick(logic [4:0] p, logic [2:0] idx);
    return (idx < 3'd5) ? p[idx] : 1'b1;
  endfunction

  task automatic apply(vec_t v);
    @(posedge clk);
    in_i      <= v.vin;
    mask_i    <= {v.m4, v.m3, v.m2, v.m1, v.m0};
    route_i   <= v.route;
    casc_en_i <= v.cen;
    casc_i    <= v.cin;
    fb_bus_i  <= v.fbin;
    fb_use_i  <= v.fbuse;
    xor_sel_i <= v.xsel;
    xor_idx_i <= v.xidx;
    fb_sel_i  <= v.fbsel;
    @(negedge clk);
  endtask

  task automatic check_vec(vec_t v, string tag);
    chk({tag, " R3 ctrl"}, 32'(ctrl_o), 32'(v.e_ctrl));
    chk({tag, " R4/R5 sum"}, 32'(sum_o), 32'(v.e_sum));
    chk({tag, " R6 casc"}, 32'(casc_o), 32'(v.e_sum));
    chk({tag, " R7/R8 xor"}, 32'(xor_o), 32'(v.e_xor));
    chk({tag, " R9 fb"}, 32'(fb_o), 32'(v.e_fb));
  endtask

  initial begin
    in_i = '0; mask_i = '0; route_i = '0; casc_en_i = 1'b0; casc_i = 1'b0;
    fb_bus_i = '0; fb_use_i = '0; xor_sel_i = 2'b00; xor_idx_i = '0; fb_sel_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: empty terms all go to control lines (R2, R3)
    chk("R2 idle ctrl", 32'(ctrl_o), 32'h1F);
    chk("R3 idle sum", 32'(sum_o), 32'h0);
    chk("R9 idle fb", 32'(fb_o), 32'h0);

    for (int n = 0; n < NV; n++) begin
      apply(TBL[n]);
      check_vec(TBL[n], $sformatf("V%0d", n));
    end

    // Random vectors checked against the bench model (R1..R10)
    for (int n = 0; n < 300; n++) begin
      vec_t v;
      logic [4:0] p;
      logic s, op;
      v.vin = 8'($urandom);
      v.m0 = 16'($urandom & $urandom); v.m1 = 16'($urandom & $urandom);
      v.m2 = 16'($urandom & $urandom & $urandom); v.m3 = 16'($urandom & $urandom & $urandom);
      v.m4 = (n % 4 == 0) ? 16'h0 : 16'($urandom & $urandom & $urandom);
      v.route = 5'($urandom); v.cen = 1'($urandom); v.cin = 1'($urandom);
      v.fbin = 4'($urandom); v.fbuse = 4'($urandom); v.xsel = 2'($urandom);
      v.xidx = 3'($urandom); v.fbsel = 3'($urandom);
      p = {term_of(v.vin, v.m4), term_of(v.vin, v.m3), term_of(v.vin, v.m2),
           term_of(v.vin, v.m1), term_of(v.vin, v.m0)};
      s = (|(p & v.route)) | (v.cen & v.cin) | (|(v.fbin & v.fbuse));
      case (v.xsel)
        2'b00: op = 1'b0;
        2'b01: op = 1'b1;
        2'b10: op = pick(p, v.xidx);
        default: op = ~pick(p, v.xidx);
      endcase
      v.e_ctrl = p & ~v.route;
      v.e_sum  = s;
      v.e_xor  = s ^ op;
      v.e_fb   = ~pick(p, v.fbsel);
      apply(v);
      check_vec(v, "RND R1");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule